// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a host reach a large internal register file through a narrow window of seven 16-bit slots. The slots are a status register, an indirect address register, four data registers and a read-only revision register. The host starts a transfer by writing an address word. That word names an internal register, selects one of its two 16-bit halves, and carries a read flag. A read copies the chosen halfword into data register 0. A write commits the data registers to the named internal register. While a transfer runs, a busy bit in the status register stays set, and the host polls it until it clears.

The internal register file is a parameterised array of 32-bit registers, stored as two 16-bit lanes so that block RAM can be inferred. The status register also holds two reset-release bits, one for the core and one for the codec. The host clears both bits to put the device into reset and sets both to release it.

The host port is a simple one-cycle register port. Every request is acknowledged on the following cycle, and read data arrives together with the acknowledge.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the status register, all four data registers and both run outputs read as zero. Every internal register reads as zero until it is first written.
- R2: A write to the status slot (offset 0) sets `core_run` from bit 1 and `codec_run` from bit 2, so writing zero holds both in reset. A read of the status slot returns busy in bit 0, `core_run` in bit 1 and `codec_run` in bit 2, with the other bits zero.
- R3: A write to the address slot (offset 1) launches a transfer. In the address word, bit 7 set means a read and bit 7 clear means a write. Bits 6:1 hold the register index and bit 0 selects the half (0 = low half, 1 = high half).
- R4: The busy bit reads 1 for exactly BUSY_CYCLES consecutive cycles, starting with the cycle after the launch, and then reads 0.
- R5: When a read completes, data register 0 holds the selected halfword of the indexed register. Data registers 1 to 3 keep their previous values.
- R6: A write with half 0 stores {data1, data0} into the register. A write with half 1 stores data0 into the upper half and leaves the lower half unchanged.
- R7: A write to the address slot while busy is set starts no transfer and does not change the transfer in progress.
- R8: A write to a data slot (offsets 2 to 5) while busy is set is ignored.
- R9: An index at or above NUM_REGS reads as zero into data register 0. A write to such an index changes no register.
- R10: The revision slot (offset 6) is read-only. It returns the board number in bits 15:12, the `codec_absent` input in bit 8, the major revision in bits 7:4 and the minor revision in bits 3:0, with all other bits zero.
- R11: Every host request is acknowledged exactly one cycle later. Read data is valid with the acknowledge, and a read of a data slot returns that slot's stored value.
- R12: A set-bit or clear-bit sequence, made of a read transfer followed by a write transfer, changes only the targeted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_req | input | 1 | Host access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_sel | input | 3 | Window slot offset |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | Acknowledge, one cycle after the request |
| host_rdata | output | 16 | Read data, valid with the acknowledge |
| codec_absent | input | 1 | Reported in bit 8 of the revision slot |
| core_run | output | 1 | Core reset release (1 = running) |
| codec_run | output | 1 | Codec reset release (1 = running) |

## Verification
Assertions check several rules on every cycle:
- the one-cycle acknowledge;
- that the busy window holds while its counter is non-zero;
- that busy rises only after a launch;
- that the latched command and the data registers stay frozen through a transfer;
- that the run bits change only after a status write;
- that an out-of-range read zeroes data register 0.

Only the bench scenarios can show the data itself: the exact busy length as the host sees it, the halfword placement of every register after a sweep of writes and reads, that aliased out-of-range writes leave in-range registers untouched, and that a read-modify-write changes a single bit.

// File: rtl/ind_bridge_pkg.sv
package ind_bridge_pkg;

  typedef enum logic [2:0] {
    WIN_STATUS = 3'd0,
    WIN_ADDR   = 3'd1,
    WIN_DATA0  = 3'd2,
    WIN_DATA1  = 3'd3,
    WIN_DATA2  = 3'd4,
    WIN_DATA3  = 3'd5,
    WIN_REV    = 3'd6
  } win_sel_e;

  localparam int IDX_FIELD_W = 6;
  localparam int HALF_W      = 16;
  localparam int NUM_DATA    = 4;

  // Address word layout: {rd, idx[5:0], half} in bits 7:0
  typedef struct packed {
    logic                   rd;
    logic [IDX_FIELD_W-1:0] idx;
    logic                   half;
  } xfer_t;

endpackage

// File: rtl/ind_xfer_seq.sv
module ind_xfer_seq
  import ind_bridge_pkg::*;
#(
  parameter int BUSY_CYCLES = 4
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  launch,
  input  xfer_t launch_cmd,
  output logic  busy,
  output logic  done,
  output xfer_t cmd_q
);

  localparam int EFF   = (BUSY_CYCLES < 2) ? 2 : BUSY_CYCLES;
  localparam int CNT_W = $clog2(EFF);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt   <= '0;
      cmd_q <= '0;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end else if (launch) begin
      busy  <= 1'b1;
      cnt   <= CNT_W'(EFF - 1);
      cmd_q <= launch_cmd;
    end
  end

  assign done = busy && (cnt == '0);

  // R4
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != '0) |=> busy);

  // R3
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(launch));

  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(cmd_q));

endmodule

// File: rtl/ind_regfile.sv
module ind_regfile #(
  parameter int NUM_REGS = 16,
  parameter int IDX_W    = 4,
  parameter int LANE_W   = 16
) (
  input  logic                   clk,
  input  logic [IDX_W-1:0]       idx,
  input  logic [1:0]             wr_en,
  input  logic [1:0][LANE_W-1:0] wr_data,
  output logic [1:0][LANE_W-1:0] rd_data
);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [LANE_W-1:0] mem [NUM_REGS];
    logic [LANE_W-1:0] q;

    initial begin
      for (int i = 0; i < NUM_REGS; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
      if (wr_en[g]) mem[idx] <= wr_data[g];
      q <= mem[idx];
    end

    assign rd_data[g] = q;
  end

endmodule

// File: rtl/ind_reg_bridge.sv
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int         NUM_REGS    = 16,
  parameter int         BUSY_CYCLES = 4,
  parameter logic [3:0] BOARD_ID    = 4'h4,
  parameter logic [3:0] MAJOR_REV   = 4'h2,
  parameter logic [3:0] MINOR_REV   = 4'h1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [2:0]  host_sel,
  input  logic [15:0] host_wdata,
  output logic        host_ack,
  output logic [15:0] host_rdata,
  input  logic        codec_absent,
  output logic        core_run,
  output logic        codec_run
);

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_FIELD_W:0] NREGS_L = NUM_REGS[IDX_FIELD_W:0];

  logic  busy, done, launch, st_wr, in_range, commit;
  xfer_t cmd_q;
  logic [NUM_DATA-1:0][HALF_W-1:0] data_q;
  logic [1:0][HALF_W-1:0] rf_rd, rf_wr;
  logic [1:0] rf_we;
  logic [15:0] rd_mux;

  assign launch = host_req && host_we && (host_sel == WIN_ADDR);
  assign st_wr  = host_req && host_we && (host_sel == WIN_STATUS);

  ind_xfer_seq #(.BUSY_CYCLES(BUSY_CYCLES)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .launch     (launch),
    .launch_cmd (xfer_t'(host_wdata[7:0])),
    .busy       (busy),
    .done       (done),
    .cmd_q      (cmd_q)
  );

  assign in_range = ({1'b0, cmd_q.idx} < NREGS_L);
  assign commit   = done && !cmd_q.rd && in_range;
  assign rf_we[0] = commit && !cmd_q.half;
  assign rf_we[1] = commit;
  assign rf_wr[0] = data_q[0];
  assign rf_wr[1] = cmd_q.half ? data_q[0] : data_q[1];

  ind_regfile #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .LANE_W(HALF_W)) u_rf (
    .clk     (clk),
    .idx     (cmd_q.idx[IDX_W-1:0]),
    .wr_en   (rf_we),
    .wr_data (rf_wr),
    .rd_data (rf_rd)
  );

  // data registers: host writes blocked while a transfer runs
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
    end else if (done && cmd_q.rd) begin
      data_q[0] <= in_range ? (cmd_q.half ? rf_rd[1] : rf_rd[0]) : '0;
    end else if (host_req && host_we && !busy) begin
      for (int k = 0; k < NUM_DATA; k++)
        if (host_sel == 3'(k + 2)) data_q[k] <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_run  <= 1'b0;
      codec_run <= 1'b0;
    end else if (st_wr) begin
      core_run  <= host_wdata[1];
      codec_run <= host_wdata[2];
    end
  end

  always_comb begin
    case (host_sel)
      WIN_STATUS: rd_mux = {13'b0, codec_run, core_run, busy};
      WIN_DATA0:  rd_mux = data_q[0];
      WIN_DATA1:  rd_mux = data_q[1];
      WIN_DATA2:  rd_mux = data_q[2];
      WIN_DATA3:  rd_mux = data_q[3];
      WIN_REV:    rd_mux = {BOARD_ID, 3'b0, codec_absent, MAJOR_REV, MINOR_REV};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      host_ack   <= 1'b0;
      host_rdata <= '0;
    end else begin
      host_ack   <= host_req;
      host_rdata <= (host_req && !host_we) ? rd_mux : '0;
    end
  end

  // R11
  ack_next_chk: assert property (@(posedge clk) disable iff (rst)
    host_req |=> host_ack);

  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !done) |=> $stable(data_q));

  // R2
  run_change_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable({core_run, codec_run}) |-> $past(st_wr));

  // R9
  oob_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q.rd && !in_range) |=> (data_q[0] == '0));

endmodule

// File: tb/sim_ind_reg_bridge.sv
`timescale 1ns/1ps
module sim_ind_reg_bridge;
  localparam int NR = 16;
  localparam int BC = 3;
  localparam logic [2:0] S_ST = 3'd0, S_AD = 3'd1, S_D0 = 3'd2, S_D1 = 3'd3,
                         S_D2 = 3'd4, S_D3 = 3'd5, S_RV = 3'd6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, req, we, absent, ack, core_run, codec_run;
  logic [2:0] sel;
  logic [15:0] wdata, rdata, v, w;
  logic [15:0] m_lo [NR];
  logic [15:0] m_hi [NR];
  int n_chk = 0, n_fail = 0, nb;
  bit finished = 0;

  ind_reg_bridge #(.NUM_REGS(NR), .BUSY_CYCLES(BC),
    .BOARD_ID(4'h4), .MAJOR_REV(4'h2), .MINOR_REV(4'h1)) u0 (
    .clk(clk), .rst(rst), .host_req(req), .host_we(we), .host_sel(sel),
    .host_wdata(wdata), .host_ack(ack), .host_rdata(rdata),
    .codec_absent(absent), .core_run(core_run), .codec_run(codec_run));

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d);
    req = 1; we = 1; sel = s; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [15:0] d);
    req = 1; we = 0; sel = s;
    @(negedge clk);
    d = rdata;
    req = 0;
  endtask

  task automatic wait_idle(output int busy_n);
    logic [15:0] s;
    busy_n = 0;
    for (int i = 0; i < 64; i++) begin
      rd(S_ST, s);
      if (!s[0]) return;
      busy_n++;
    end
    chk("R4 busy never cleared", 16'h1, 16'h0);
  endtask

  task automatic xwrite(input int idx, input bit half, input logic [15:0] lo, input logic [15:0] hi);
    wr(S_D0, lo); wr(S_D1, hi); wr(S_D2, 0); wr(S_D3, 0);
    wr(S_AD, 16'((idx << 1) | int'(half)));
    wait_idle(nb);
  endtask

  task automatic xread(input int idx, input bit half, output logic [15:0] d);
    wr(S_AD, 16'(16'h80 | (idx << 1) | int'(half)));
    wait_idle(nb);
    rd(S_D0, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1; req = 0; we = 0; sel = 0; wdata = 0; absent = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rd(S_ST, v); chk("R1 status", v, 16'h0);
    for (int k = 0; k < 4; k++) begin
      rd(3'(k + 2), v); chk("R1 data reg", v, 16'h0);
    end
    chk("R1 run outputs", {14'b0, core_run, codec_run}, 16'h0);
    xread(0, 0, v); chk("R1 regfile zero", v, 16'h0);

    // R11 ack timing
    req = 1; we = 0; sel = S_RV; @(posedge clk); #1 req = 0;
    @(negedge clk); chk("R11 ack", {15'b0, ack}, 16'h1);
    chk("R11 rdata with ack", rdata, 16'h4021);
    @(negedge clk); chk("R11 ack drops", {15'b0, ack}, 16'h0);

    // R10 revision
    absent = 1; rd(S_RV, v); chk("R10 rev absent", v, 16'h4121);
    absent = 0; wr(S_RV, 16'hFFFF); rd(S_RV, v); chk("R10 rev read-only", v, 16'h4021);

    // R2 status / reset bits
    wr(S_ST, 16'h0006); rd(S_ST, v); chk("R2 status both", v, 16'h0006);
    chk("R2 ports both", {14'b0, core_run, codec_run}, 16'h3);
    wr(S_ST, 16'h0002); chk("R2 core only", {14'b0, core_run, codec_run}, 16'h2);
    wr(S_ST, 16'h0000); rd(S_ST, v); chk("R2 status zero", v, 16'h0);

    // R4 busy length
    wr(S_D0, 16'h1234); wr(S_D1, 16'h0); wr(S_AD, 16'h0000);
    wait_idle(nb); chk("R4 busy cycles", 16'(nb), 16'(BC));

    // R3/R6 write sweep
    for (int i = 0; i < NR; i++) begin
      m_lo[i] = 16'(i * 16'h1357 + 16'h0101);
      m_hi[i] = 16'(i * 16'h2468) ^ 16'hA5A5;
      xwrite(i, 0, m_lo[i], m_hi[i]);
    end
    // R3/R5 read sweep of both halves
    for (int i = 0; i < NR; i++) begin
      xread(i, 0, v); chk("R5 low half", v, m_lo[i]);
      xread(i, 1, v); chk("R5 high half", v, m_hi[i]);
    end
    // R5 data1 untouched by reads
    rd(S_D1, v); chk("R5 data1 kept", v, m_hi[NR-1]);

    // R6 upper-half write
    xwrite(9, 1, 16'h7777, 16'hDEAD); m_hi[9] = 16'h7777;
    xread(9, 0, v); chk("R6 low preserved", v, m_lo[9]);
    xread(9, 1, v); chk("R6 high written", v, 16'h7777);

    // R7 address write while busy ignored
    wr(S_AD, 16'h0080 | (5 << 1));
    wr(S_AD, 16'h0080 | (6 << 1));
    wait_idle(nb); chk("R7 busy not restarted", 16'(nb), 16'(BC - 1));
    rd(S_D0, v); chk("R7 first transfer kept", v, m_lo[5]);

    // R8 data write while busy ignored
    wr(S_D0, 16'h1111); wr(S_D1, 16'h2222);
    wr(S_AD, 16'(7 << 1));
    wr(S_D0, 16'hBEEF); wr(S_D1, 16'hCAFE);
    wait_idle(nb);
    rd(S_D0, v); chk("R8 data0 unchanged", v, 16'h1111);
    rd(S_D1, v); chk("R8 data1 unchanged", v, 16'h2222);
    m_lo[7] = 16'h1111; m_hi[7] = 16'h2222;
    xread(7, 0, v); chk("R8 committed low", v, 16'h1111);
    xread(7, 1, v); chk("R8 committed high", v, 16'h2222);

    // R9 out-of-range index
    xwrite(16 + 3, 0, 16'h5A5A, 16'hA5A5);
    xread(3, 0, v); chk("R9 alias low", v, m_lo[3]);
    xread(3, 1, v); chk("R9 alias high", v, m_hi[3]);
    xread(16 + 3, 0, v); chk("R9 oob read zero", v, 16'h0);
    xread(63, 1, v); chk("R9 top index zero", v, 16'h0);

    // R12 set bit then clear bit via read-modify-write
    xread(2, 0, v); xread(2, 1, w);
    xwrite(2, 0, v | 16'h0040, w); m_lo[2] = m_lo[2] | 16'h0040;
    xread(2, 0, v); chk("R12 set bit low", v, m_lo[2]);
    xread(2, 1, v); chk("R12 set bit high", v, m_hi[2]);
    xread(2, 0, v); xread(2, 1, w);
    xwrite(2, 0, v & ~16'h0001, w); m_lo[2] = m_lo[2] & ~16'h0001;
    xread(2, 0, v); chk("R12 clear bit low", v, m_lo[2]);
    xread(4, 0, v); chk("R12 neighbour intact", v, m_lo[4]);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule